// File: doc/BRIEF.md
# Layer Phase Sequencer

This block orders the work phases of one convolution layer. It waits in idle until a start pulse arrives. It then steps through six work phases: it fetches the layer parameters, loads the 8-bit centroid palette, loads the 2-bit weight codes, fetches the input tile, drains the pipeline, and runs one input-channel pass. An external datapath carries out each phase and reports its end with a one-cycle pulse on that phase's own bit of a done vector.

After the channel pass, a loop-back pulse sends the sequencer back to the weight-code load. The next channel group therefore reuses the palette and only reloads the compact codes. The sequencer reaches the finish state when the channel pass ends without a loop-back. In the finish state it raises a one-cycle completion flag and then returns to idle.

The current work phase is shown on a registered one-hot enable vector. A busy flag is high in every work phase.

Top module: `layer_phase_seq`

## Requirements
- R1: After the asynchronous active-low reset `rst_ni`, `phase_en_o` is 0, `busy_o` is 0 and `done_o` is 0 (idle).
- R2: In idle, the sequencer stays idle while `start_i` is low. A high `start_i` at a clock edge moves it to the parameter phase, with `phase_en_o` = 6'b000001 after that edge.
- R3: The bit positions of `phase_en_o` and `phase_done_i` are: bit 0 parameters, bit 1 palette, bit 2 weight codes, bit 3 input tile, bit 4 drain, bit 5 channel pass. In phases 0 to 4, the sequencer moves to the next bit position when that phase's own done bit is high at a clock edge. Done bits of other phases are ignored.
- R4: In the channel pass (bit 5), a high `loop_i` returns the sequencer to the weight-code phase (bit 2).
- R5: When `loop_i` and `phase_done_i[5]` are high together in the channel pass, the loop-back wins.
- R6: The palette phase (bit 1) is entered only from the parameter phase. It is therefore visited once per run, whatever the number of loop-backs.
- R7: When `phase_done_i[5]` is high and `loop_i` is low in the channel pass, the next cycle is the finish state: `done_o` = 1, `busy_o` = 0 and `phase_en_o` = 0 for exactly one cycle. The cycle after that is idle.
- R8: `start_i` has no effect outside idle.
- R9: `phase_en_o` is registered and has exactly one bit set in each work phase and none in idle or finish. `busy_o` is high exactly in the work phases.
- R10: Asserting `rst_ni` in the middle of a run returns the sequencer to idle at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Run request, sampled only in idle |
| phase_done_i | input | 6 | Per-phase finished pulses, bit positions as in R3 |
| loop_i | input | 1 | Another input-channel group remains |
| phase_en_o | output | 6 | One-hot phase enables, bit positions as in R3 |
| busy_o | output | 1 | A work phase is active |
| done_o | output | 1 | One-cycle completion flag |

## Verification
The checker tests these properties on every cycle:
- the one-hot shape of the enables;
- phases advance only on their own done bit;
- the loop-back target and its priority over the channel done;
- the palette can only follow the parameter phase;
- the single-cycle finish flag;
- start having no effect during a run.

Only the bench scenarios can show the following:
- the reset values;
- the return to idle under an asynchronous reset in the middle of a run;
- that a multi-pass run touches the palette exactly once.

The bench also compares every cycle of a long run with random inputs against its own reference model.

// File: rtl/layer_phase_seq_pkg.sv
package layer_phase_seq_pkg;
  localparam int unsigned NUM_WORK = 6;
  localparam int unsigned ST_W     = $clog2(NUM_WORK + 2);

  typedef enum logic [ST_W-1:0] {
    ST_IDLE    = 3'd0,
    ST_PARAM   = 3'd1,
    ST_PALETTE = 3'd2,
    ST_CODES   = 3'd3,
    ST_TILE    = 3'd4,
    ST_DRAIN   = 3'd5,
    ST_CHAN    = 3'd6,
    ST_FINISH  = 3'd7
  } seq_state_e;

  // enable bit k belongs to state k+1
  localparam int unsigned CODES_BIT = 2;
  localparam int unsigned CHAN_BIT  = 5;
endpackage

// File: rtl/seq_next_state.sv
module seq_next_state
  import layer_phase_seq_pkg::*;
(
  input  seq_state_e          state_i,
  input  logic                start_i,
  input  logic [NUM_WORK-1:0] phase_done_i,
  input  logic                loop_i,
  output seq_state_e          next_o
);
  always_comb begin
    next_o = state_i;
    unique case (state_i)
      ST_IDLE:   if (start_i) next_o = ST_PARAM;
      ST_CHAN: begin
        if (loop_i)                      next_o = ST_CODES;  // loop-back wins
        else if (phase_done_i[CHAN_BIT]) next_o = ST_FINISH;
      end
      ST_FINISH: next_o = ST_IDLE;
      default: begin
        if (phase_done_i[ST_W'(state_i) - ST_W'(1)])
          next_o = seq_state_e'(state_i + ST_W'(1));
      end
    endcase
  end
endmodule

// File: rtl/seq_state_reg.sv
module seq_state_reg
  import layer_phase_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_state_e next_i,
  output seq_state_e state_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= ST_IDLE;
    else         state_o <= next_i;
  end
endmodule

// File: rtl/seq_out_reg.sv
module seq_out_reg
  import layer_phase_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  seq_state_e          next_i,
  output logic [NUM_WORK-1:0] phase_en_o,
  output logic                busy_o,
  output logic                done_o
);
  // outputs registered from next state so they line up with the state register
  for (genvar k = 0; k < NUM_WORK; k++) begin : g_en
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) phase_en_o[k] <= 1'b0;
      else         phase_en_o[k] <= (next_i == seq_state_e'(k + 1));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      busy_o <= (next_i != ST_IDLE) && (next_i != ST_FINISH);
      done_o <= (next_i == ST_FINISH);
    end
  end
endmodule

// File: rtl/layer_phase_seq.sv
module layer_phase_seq
  import layer_phase_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic [NUM_WORK-1:0] phase_done_i,
  input  logic                loop_i,
  output logic [NUM_WORK-1:0] phase_en_o,
  output logic                busy_o,
  output logic                done_o
);
  seq_state_e state_q, state_d;

  seq_next_state u_next (
    .state_i      (state_q),
    .start_i      (start_i),
    .phase_done_i (phase_done_i),
    .loop_i       (loop_i),
    .next_o       (state_d)
  );

  seq_state_reg u_state (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .next_i  (state_d),
    .state_o (state_q)
  );

  seq_out_reg u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .next_i     (state_d),
    .phase_en_o (phase_en_o),
    .busy_o     (busy_o),
    .done_o     (done_o)
  );
endmodule

// File: rtl/layer_phase_seq_chk.sv
module layer_phase_seq_chk
  import layer_phase_seq_pkg::*;
(
  input logic                clk_i,
  input logic                rst_ni,
  input logic                start_i,
  input logic [NUM_WORK-1:0] phase_done_i,
  input logic                loop_i,
  input logic [NUM_WORK-1:0] phase_en_o,
  input logic                busy_o,
  input logic                done_o
);
  logic idle;
  assign idle = !busy_o && !done_o;

  assert_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(phase_en_o) && (busy_o == (phase_en_o != '0)));

  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && !start_i |=> idle && (phase_en_o == '0));

  assert_idle_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle && start_i |=> phase_en_o == NUM_WORK'(1));

  for (genvar k = 0; k < NUM_WORK - 1; k++) begin : g_step
    assert_advance_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_en_o[k] && phase_done_i[k] |=> phase_en_o[k+1]);
    assert_wait_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      phase_en_o[k] && !phase_done_i[k] |=> $stable(phase_en_o));
  end

  assert_loop_R4_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_en_o[CHAN_BIT] && loop_i |=> phase_en_o[CODES_BIT]);

  assert_palette_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(phase_en_o[1]) |-> $past(phase_en_o[0]));

  assert_finish_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_en_o[CHAN_BIT] && phase_done_i[CHAN_BIT] && !loop_i |=> done_o && !busy_o);

  assert_done_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o && !busy_o && (phase_en_o == '0));

  assert_start_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i && (phase_done_i == '0) && !loop_i |=> $stable(phase_en_o));
endmodule

bind layer_phase_seq layer_phase_seq_chk u_chk (.*);

// File: tb/layer_phase_seq_tb_top.sv
`timescale 1ns/1ps
module layer_phase_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [5:0] pdone = '0;
  logic       loop = 1'b0;
  logic [5:0] en;
  logic       busy, fin;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int m = 0;  // model phase: 0 idle, 1..6 work, 7 finish
  int pal_visits = 0;

  always #2.5 clk = ~clk;

  layer_phase_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .phase_done_i(pdone),
    .loop_i(loop), .phase_en_o(en), .busy_o(busy), .done_o(fin)
  );

  // behavioural reference
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m <= 0;
    else if (m == 0) begin if (start) m <= 1; end
    else if (m == 6) begin
      if (loop) m <= 3;
      else if (pdone[5]) m <= 7;
    end
    else if (m == 7) m <= 0;
    else if (pdone[m-1]) m <= m + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int exp_en(input int s);
    return (s >= 1 && s <= 6) ? (1 << (s - 1)) : 0;
  endfunction

  // one cycle: drive at negedge, compare at next negedge
  task automatic step(input bit s, input logic [5:0] d, input bit l);
    start = s; pdone = d; loop = l;
    @(negedge clk);
    cyc++;
    if (en[1]) pal_visits++;
    chk(en == 6'(exp_en(m)), "R9 enables", en, exp_en(m));
    chk(busy == (m >= 1 && m <= 6), "R9 busy", busy, (m >= 1 && m <= 6));
    chk(fin == (m == 7), "R7 done", fin, (m == 7));
  endtask

  task automatic reset_seq();
    rst_n = 1'b0; start = 0; pdone = '0; loop = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual expired expected finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    reset_seq();
    chk(en == 0 && !busy && !fin, "R1 reset", {en, busy, fin}, 0);

    step(0, '0, 0); step(0, 6'h3f, 1);
    chk(en == 0 && !busy, "R2 stays idle", en, 0);
    step(1, '0, 0);
    chk(en == 6'b000001, "R2 start", en, 1);
    step(1, '0, 0);
    chk(en == 6'b000001, "R8 start ignored", en, 1);
    step(0, 6'b111110, 1);
    chk(en == 6'b000001, "R3 foreign done", en, 1);
    step(0, 6'b000001, 0);
    chk(en == 6'b000010, "R3 to palette", en, 2);
    step(0, 6'b000010, 0); step(0, 6'b000100, 0); step(0, 6'b001000, 0);
    step(0, 6'b010000, 0);
    chk(en == 6'b100000, "R3 to channel", en, 32);
    step(0, '0, 1);
    chk(en == 6'b000100, "R4 loop-back", en, 4);
    step(0, 6'b000100, 0); step(0, 6'b001000, 0); step(0, 6'b010000, 0);
    step(0, 6'b100000, 1);
    chk(en == 6'b000100, "R5 loop priority", en, 4);
    step(0, 6'b000100, 0); step(0, 6'b001000, 0); step(0, 6'b010000, 0);
    step(1, 6'b100000, 0);
    chk(fin && !busy && en == 0, "R7 finish", {en, busy, fin}, 1);
    chk(pal_visits == 1, "R6 palette once", pal_visits, 1);
    step(1, '0, 0);
    chk(!fin && !busy && en == 0, "R7 back to idle", {en, busy, fin}, 0);

    step(1, '0, 0); step(0, 6'b000001, 0); step(0, 6'b000010, 0);
    #1 rst_n = 1'b0; #1;
    chk(en == 0 && !busy && !fin, "R10 async reset", {en, busy, fin}, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 3000; i++) begin
      logic [5:0] d;
      d = 6'($urandom) & 6'($urandom);
      step(($urandom % 4) == 0, d, ($urandom % 3) == 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule